// File: doc/BRIEF.md
# Serial Flash Burst Reader

This block is a host-side controller for a serial NOR flash on a single-lane SPI bus in mode 0 (clock idles low, data launched while the clock is low, sampled on the rising edge). A one-cycle `start` pulse with a 24-bit start address and a 16-bit byte count begins a request. On the first request after reset, the block first sends the wake-up command in a frame of its own. It then keeps chip select high for a programmable recovery time. Next it opens a single read frame: the fast-read command, the address, one dummy byte, and then as many data bytes as were requested. Chip select stays low from the command to the last data byte.

Each data byte is offered on a valid/ready byte port. While the consumer holds off, the serial clock simply stops low between bytes, so no buffering is needed. Requests whose byte range would run past the 2 MiB device size are refused with an error pulse and never reach the bus. A zero-length request completes at once.

The serial clock is the system clock divided by an even parameter. The recovery wait is a count of system clock cycles. A parameter makes the wake sequence run before every request instead of only the first.

Top module: `spi_flash_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `rd_valid`, `done` and `err` are 0.
- R2: The first accepted non-empty request after reset begins with a frame that carries exactly eight clocks shifting the byte 0xAB, MSB first. Chip select rises straight after that frame.
- R3: After the wake frame, chip select stays high for at least `WAKE_GAP_CYCLES` system clock cycles before the read frame begins.
- R4: With `ALWAYS_WAKE` = 0, later requests skip the wake frame. They go straight to the read frame, with no 0xAB frame.
- R5: A read frame shifts 0x0B, then the 24-bit start address MSB first, then 8 dummy clocks, and only then data clocks. `spi_mosi` never changes while `spi_sck` is high, and `spi_sck` is low whenever `spi_cs_n` is high.
- R6: Data byte k of a request equals the flash byte at start address + k. It is built MSB first from `spi_miso` sampled on the rising `spi_sck` edges. The bytes are delivered in order on `rd_data`, and exactly byte count bytes are delivered. Chip select stays low for the whole burst.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1, `rd_data` holds its value and `spi_sck` stays low.
- R8: A request is refused when start address + byte count > 0x200000. A refused request gives a one-cycle `err` pulse in the cycle after `start`, raises no `busy` and opens no frame. A request ending exactly at 0x200000 is served.
- R9: A request with byte count 0 gives a one-cycle `done` pulse in the cycle after `start` and opens no frame.
- R10: `busy` is 1 from the cycle after an accepted `start` until after `done`. `done` is a one-cycle pulse in the cycle after the last byte handshake, with chip select already high. `start` pulses while `busy` is 1 are ignored.
- R11: Each `spi_sck` period inside a byte is `CLK_DIV` system cycles, with the high phase `CLK_DIV`/2 cycles. Between any two frames, chip select is high for at least `CLK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| start_addr | input | 24 | Byte address of the first byte to read |
| byte_count | input | LEN_W | Number of bytes to read |
| rd_data | output | 8 | Data byte offered to the consumer |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer takes the byte when high with `rd_valid` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is refused |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong header index or address register shows up in the first data byte of a burst. The bench flash model then returns bytes from the wrong location, or shifted by whole bits, and the mismatch appears at the first handshake. A stale wake flag shows as a missing or extra 0xAB frame, or as a recovery gap that is too short. A counter off by one in the bit engine changes the clocks per byte and breaks every following byte, as well as the measured SCK high time within the same byte. Refusal and zero-length paths are checked in the cycle directly after `start`.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

   localparam logic [7:0] CMD_WAKE = 8'hAB;
   localparam logic [7:0] CMD_READ = 8'h0B;
   localparam int         ADDR_W   = 24;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_GAP,
      ST_HDR,
      ST_DATA,
      ST_HOLD,
      ST_TAIL
   } rd_state_t;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);

   localparam int HALF = CLK_DIV / 2;
   localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   logic            active;
   logic [PH_W-1:0] ph;
   logic [2:0]      bitn;
   logic [7:0]      txsh;
   logic [7:0]      rxsh;
   logic            sck_q;
   logic            done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= '0;
         bitn   <= '0;
         txsh   <= '0;
         rxsh   <= '0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               ph     <= '0;
               bitn   <= '0;
               txsh   <= tx;
            end
         end else begin
            if (ph == PH_W'(HALF - 1)) begin
               sck_q <= 1'b1;
               rxsh  <= {rxsh[6:0], miso};
            end
            if (ph == PH_W'(CLK_DIV - 1)) begin
               sck_q <= 1'b0;
               ph    <= '0;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
                  txsh <= {txsh[6:0], 1'b0};
               end
            end else begin
               ph <= ph + PH_W'(1);
            end
         end
      end
   end

   assign sck  = sck_q;
   assign mosi = txsh[7];
   assign done = done_q;
   assign rx   = rxsh;

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= val;
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
   import spi_rd_pkg::*;
#(
   parameter int CLK_DIV         = 4,
   parameter int WAKE_GAP_CYCLES = 300,
   parameter bit ALWAYS_WAKE     = 1'b0,
   parameter int LEN_W           = 16,
   parameter int MEM_BYTES       = 2097152
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [23:0]       start_addr,
   input  logic [LEN_W-1:0]  byte_count,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int SUM_W   = ADDR_W + 1;
   localparam int TIM_MAX = (WAKE_GAP_CYCLES > CLK_DIV) ? WAKE_GAP_CYCLES : CLK_DIV;
   localparam int TIM_W   = $clog2(TIM_MAX + 1);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (WAKE_GAP_CYCLES < CLK_DIV) begin : g_bad_gap
      $error("WAKE_GAP_CYCLES must be at least CLK_DIV");
   end
   if (LEN_W < 1 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("LEN_W must lie between 1 and 23");
   end
   if (MEM_BYTES < 1 || MEM_BYTES > (1 << ADDR_W)) begin : g_bad_mem
      $error("MEM_BYTES must fit the 24-bit address space");
   end

   rd_state_t         state;
   logic [2:0]        idx;
   logic [LEN_W-1:0]  remain;
   logic [23:0]       addr_q;
   logic              woken;
   logic              need_wake;
   logic              out_of_range;

   logic              eng_go;
   logic [7:0]        eng_tx;
   logic              eng_done;
   logic [7:0]        eng_rx;

   logic              tim_load;
   logic [TIM_W-1:0]  tim_val;
   logic              tim_exp;

   logic              hs;

   if (ALWAYS_WAKE) begin : g_wake_always
      assign need_wake = 1'b1;
   end else begin : g_wake_once
      assign need_wake = !woken;
   end

   assign out_of_range = ({1'b0, start_addr} + SUM_W'(byte_count)) > SUM_W'(MEM_BYTES);
   assign hs           = rd_valid && rd_ready;

   function automatic logic [7:0] hdr_byte(input logic [2:0] i, input logic [23:0] a);
      case (i)
         3'd0:    return CMD_READ;
         3'd1:    return a[23:16];
         3'd2:    return a[15:8];
         3'd3:    return a[7:0];
         default: return 8'h00;
      endcase
   endfunction

   always_comb begin
      eng_go = 1'b0;
      eng_tx = 8'h00;
      case (state)
         ST_IDLE: begin
            if (start && !out_of_range && byte_count != '0) begin
               eng_go = 1'b1;
               eng_tx = need_wake ? CMD_WAKE : CMD_READ;
            end
         end
         ST_GAP: begin
            if (tim_exp) begin
               eng_go = 1'b1;
               eng_tx = CMD_READ;
            end
         end
         ST_HDR: begin
            if (eng_done) begin
               eng_go = 1'b1;
               eng_tx = (idx == 3'd4) ? 8'h00 : hdr_byte(idx + 3'd1, addr_q);
            end
         end
         ST_HOLD: begin
            if (hs && remain != '0) begin
               eng_go = 1'b1;
               eng_tx = 8'h00;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      tim_load = 1'b0;
      tim_val  = TIM_W'(CLK_DIV);
      if (state == ST_WAKE && eng_done) begin
         tim_load = 1'b1;
         tim_val  = TIM_W'(WAKE_GAP_CYCLES);
      end else if (state == ST_HOLD && hs && remain == '0) begin
         tim_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         remain   <= '0;
         addr_q   <= '0;
         woken    <= 1'b0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         spi_cs_n <= 1'b1;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (out_of_range) begin
                     err <= 1'b1;
                  end else if (byte_count == '0) begin
                     done <= 1'b1;
                  end else begin
                     spi_cs_n <= 1'b0;
                     remain   <= byte_count;
                     addr_q   <= start_addr;
                     idx      <= '0;
                     state    <= need_wake ? ST_WAKE : ST_HDR;
                  end
               end
            end
            ST_WAKE: begin
               if (eng_done) begin
                  spi_cs_n <= 1'b1;
                  state    <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tim_exp) begin
                  spi_cs_n <= 1'b0;
                  woken    <= 1'b1;
                  idx      <= '0;
                  state    <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (eng_done) begin
                  if (idx == 3'd4)
                     state <= ST_DATA;
                  else
                     idx <= idx + 3'd1;
               end
            end
            ST_DATA: begin
               if (eng_done) begin
                  rd_data  <= eng_rx;
                  rd_valid <= 1'b1;
                  remain   <= remain - LEN_W'(1);
                  state    <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (hs) begin
                  rd_valid <= 1'b0;
                  if (remain == '0) begin
                     done     <= 1'b1;
                     spi_cs_n <= 1'b1;
                     state    <= ST_TAIL;
                  end else begin
                     state <= ST_DATA;
                  end
               end
            end
            ST_TAIL: begin
               if (tim_exp)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_engine (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (eng_go),
      .tx    (eng_tx),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .done  (eng_done),
      .rx    (eng_rx)
   );

   spi_gap_timer #(.W(TIM_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tim_load),
      .val     (tim_val),
      .expired (tim_exp)
   );

endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk #(
   parameter int CLK_DIV         = 4,
   parameter int WAKE_GAP_CYCLES = 300
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic       spi_cs_n,
   input logic       spi_sck,
   input logic       spi_mosi
);

   localparam int SAT   = WAKE_GAP_CYCLES + 1;
   localparam int CNT_W = $clog2(SAT + 1);

   logic [CNT_W-1:0] hi_cnt;
   logic [3:0]       edges;
   logic             cs_d;
   logic             sck_d;
   logic             last_wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= CNT_W'(SAT);
         edges     <= '0;
         cs_d      <= 1'b1;
         sck_d     <= 1'b0;
         last_wake <= 1'b0;
      end else begin
         cs_d  <= spi_cs_n;
         sck_d <= spi_sck;
         if (spi_cs_n) begin
            if (hi_cnt != CNT_W'(SAT))
               hi_cnt <= hi_cnt + CNT_W'(1);
         end else begin
            hi_cnt <= '0;
         end
         if (spi_cs_n && !cs_d)
            last_wake <= (edges == 4'd8);
         if (spi_cs_n && cs_d)
            edges <= '0;
         else if (!spi_cs_n && spi_sck && !sck_d && edges != 4'hF)
            edges <= edges + 4'd1;
      end
   end

   // R3 / R11: chip select high long enough before each new frame
   p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && cs_d) |->
         (int'(hi_cnt) >= (last_wake ? WAKE_GAP_CYCLES : CLK_DIV)));

   p_idle_sck_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !spi_sck));

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (spi_cs_n && !busy && !done));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && busy) |-> spi_cs_n);

endmodule

bind spi_flash_reader spi_flash_reader_chk #(
   .CLK_DIV         (CLK_DIV),
   .WAKE_GAP_CYCLES (WAKE_GAP_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_data  (rd_data),
   .rd_valid (rd_valid),
   .rd_ready (rd_ready),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .spi_cs_n (spi_cs_n),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi)
);

// File: tb/spi_flash_reader_bench.sv
`timescale 1ns/1ns
module spi_flash_reader_bench;

   localparam int PERIOD = 10;
   localparam int DIV    = 4;
   localparam int GAP    = 40;
   localparam int LEN_W  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [23:0]      start_addr = '0;
   logic [LEN_W-1:0] byte_count = '0;
   logic [7:0]       rd_data;
   logic             rd_valid;
   logic             rd_ready = 1'b0;
   logic             busy, done, err;
   logic             spi_cs_n, spi_sck, spi_mosi;
   logic             spi_miso = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   spi_flash_reader #(
      .CLK_DIV(DIV), .WAKE_GAP_CYCLES(GAP), .ALWAYS_WAKE(1'b0), .LEN_W(LEN_W)
   ) u_spi_flash_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .busy(busy), .done(done), .err(err),
      .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   function automatic logic [7:0] fmem(input int a);
      return 8'((a * 37) ^ (a >> 9) ^ 8'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // flash model
   int          bits = 0;
   int          frames = 0;
   int          wake_frames = 0;
   int          read_frames = 0;
   int          bad_frames = 0;
   int          timing_bad = 0;
   logic [7:0]  cmd = '0;
   logic [23:0] maddr = '0;
   logic [23:0] last_addr = '0;
   bit          prev_wake = 1'b0;
   longint      last_cs_rise = 0;
   longint      last_sck_rise = 0;
   longint      gap_after_wake = 0;
   longint      min_gap = 64'h7FFFFFFF;

   always @(negedge spi_cs_n) begin
      if (frames > 0) begin
         if (prev_wake) gap_after_wake = $time - last_cs_rise;
         if ($time - last_cs_rise < min_gap) min_gap = $time - last_cs_rise;
      end
      frames++;
      bits = 0;
   end

   always @(posedge spi_cs_n) begin
      if (frames > 0) begin
         last_cs_rise = $time;
         prev_wake = (bits == 8 && cmd == 8'hAB);
         if (prev_wake) wake_frames++;
         else if (cmd == 8'h0B && bits >= 40) last_addr = maddr;
         else bad_frames++;
      end
   end

   always @(posedge spi_sck) begin
      if (!spi_cs_n) begin
         if (bits % 8 != 0 && $time - last_sck_rise != DIV * PERIOD) timing_bad++;
         last_sck_rise = $time;
         if (bits < 8) cmd = {cmd[6:0], spi_mosi};
         else if (bits < 32) maddr = {maddr[22:0], spi_mosi};
         bits++;
         if (bits == 8 && cmd == 8'h0B) read_frames++;
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n) begin
         if ($time - last_sck_rise != (DIV / 2) * PERIOD) timing_bad++;
         if (bits >= 40) begin
            int k;
            logic [7:0] b;
            k = bits - 40;
            b = fmem(int'(maddr) + k / 8);
            spi_miso = b[7 - (k % 8)];
         end
      end
   end

   task automatic run_xfer(input int addr, input int len, input int stall_mode,
                           input int exp_wake, input bit poke);
      int got = 0;
      int stall = 0;
      int stall_bad = 0;
      int w0 = wake_frames;
      int r0 = read_frames;
      bit seen_done = 1'b0;
      bit poked = 1'b0;
      int guard = 0;
      @(negedge clk);
      start = 1'b1; start_addr = 24'(addr); byte_count = LEN_W'(len); rd_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
      while (!seen_done && guard < 20000) begin
         guard++;
         start = 1'b0;
         if (rd_valid && rd_ready) begin
            chk(rd_data === fmem(addr + got), "R6 data byte", int'(rd_data), int'(fmem(addr + got)));
            got++;
            stall = stall_mode ? ((got * 3 + addr) % 4) : 0;
            if (poke && !poked) begin
               start = 1'b1; start_addr = 24'h000777; byte_count = 16'd2; poked = 1'b1;
            end
         end
         if (done) seen_done = 1'b1;
         if (rd_valid && !rd_ready && spi_sck) stall_bad++;
         rd_ready = (stall == 0);
         if (stall > 0) stall--;
         @(negedge clk);
      end
      start = 1'b0;
      rd_ready = 1'b0;
      chk(seen_done, "R10 done seen", int'(seen_done), 1);
      chk(got == len, "R6 byte count", got, len);
      chk(stall_bad == 0, "R7 sck low during stall", stall_bad, 0);
      chk(read_frames - r0 == 1, "R5 one read frame", read_frames - r0, 1);
      chk(int'(last_addr) == addr, "R5 address shifted", int'(last_addr), addr);
      chk(wake_frames - w0 == exp_wake, exp_wake ? "R2 wake frame" : "R4 no wake frame",
          wake_frames - w0, exp_wake);
      guard = 0;
      while (busy && guard < 100) begin guard++; @(negedge clk); end
      chk(!busy, "R10 busy clears", int'(busy), 0);
   endtask

   task automatic try_refuse(input int addr, input int len, input bit exp_err);
      int f0 = frames;
      @(negedge clk);
      start = 1'b1; start_addr = 24'(addr); byte_count = LEN_W'(len);
      @(negedge clk);
      start = 1'b0;
      if (exp_err) begin
         chk(err === 1'b1, "R8 err pulse", int'(err), 1);
         chk(busy === 1'b0, "R8 no busy", int'(busy), 0);
      end else begin
         chk(done === 1'b1, "R9 done pulse", int'(done), 1);
         chk(busy === 1'b0, "R9 no busy", int'(busy), 0);
      end
      @(negedge clk);
      chk(err === 1'b0 && done === 1'b0, exp_err ? "R8 one cycle" : "R9 one cycle",
          int'({err, done}), 0);
      repeat (3 * DIV) @(negedge clk);
      chk(frames == f0 && spi_cs_n === 1'b1, exp_err ? "R8 no frame" : "R9 no frame",
          frames - f0, 0);
   endtask

   initial begin : main
      int addrs [4];
      addrs[0] = 24'h000000; addrs[1] = 24'h0001FE; addrs[2] = 24'h012345; addrs[3] = 24'h1FFFF0;
      repeat (3) @(negedge clk);
      chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 bus idle in reset", int'({spi_cs_n, spi_sck}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !rd_valid && !done && !err, "R1 outputs low",
          int'({busy, rd_valid, done, err}), 0);

      run_xfer(24'h000100, 4, 0, 1, 1'b0);
      chk(gap_after_wake >= GAP * PERIOD, "R3 recovery gap",
          int'(gap_after_wake / PERIOD), GAP);
      run_xfer(24'h000100, 3, 1, 0, 1'b0);

      for (int a = 0; a < 4; a++)
         for (int l = 1; l <= 6; l++)
            for (int s = 0; s < 2; s++)
               run_xfer(addrs[a], l, s, 0, 1'b0);

      run_xfer(24'h1FFFFC, 4, 1, 0, 1'b0);
      try_refuse(24'h1FFFFD, 4, 1'b1);
      try_refuse(24'h200000, 1, 1'b1);
      try_refuse(24'hFFFFFF, 16'hFFFF, 1'b1);
      try_refuse(24'h000010, 0, 1'b0);
      run_xfer(24'h000040, 5, 1, 0, 1'b1);

      chk(timing_bad == 0, "R11 sck timing", timing_bad, 0);
      chk(min_gap >= DIV * PERIOD, "R11 cs gap", int'(min_gap / PERIOD), DIV);
      chk(bad_frames == 0, "R5 frame shape", bad_frames, 0);
      chk(wake_frames == 1, "R4 single wake", wake_frames, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule